// File: doc/BRIEF.md
# I2C Master Serial-Clock Rate Generator

This block produces the serial clock timing for an I2C master. A baud-rate enable pulse arrives in the system clock domain, at most one every four system clocks. It is divided first by a selectable power-of-two prescaler and then by a programmable 8-bit divider. Each SCL half period lasts (divider + 3) prescaled units. The full SCL period is therefore twice that, so the rate is the baud clock over ((divider + 3) × prescale × 2). Divider settings that would make a half period shorter than 24 baud-clock ticks are held at 24 ticks. This caps SCL at one 48th of the baud clock.

Outputs: the SCL level, a toggle strobe on each SCL edge, a half-period tick for the byte shifter, and a flag that marks the bus as free. When a stop is requested, SCL is parked high at the next half-period boundary. The block then waits one half period as the stop-setup window and a second half period as the bus-free window, and then raises the free flag. One half period is longer than the required 1/(2.2 × fSCL) gap between a stop and the next start. New divider or prescaler values are taken only at a half-period boundary, so SCL never shows a short pulse.

Top module: `i2c_scl_rategen`

## Requirements
- R1: While `enable` is low, and from reset, `scl_o` is 1, `half_tick`, `scl_toggle` and `bus_free` are 0, and all counters are cleared; the output values hold from the first clock edge after `enable` is sampled low.
- R2: With `enable` high and no stop pending, each SCL half period lasts exactly (`div_val` + 3) × P baud ticks, where `pre_sel` 0, 1, 2, 3 gives P = 1, 4, 16, 32. After `enable` rises with SCL high, SCL first falls on the last tick of the first half period.
- R3: A half period never lasts fewer than 24 baud ticks: with P = 1 any `div_val` below 21, and with P = 4 any `div_val` below 3, gives a half period of exactly 24 ticks.
- R4: `half_tick` is a one-cycle pulse in the cycle after each half-period boundary, and `scl_toggle` pulses in that same cycle whenever `scl_o` changed.
- R5: `div_val` and `pre_sel` are sampled only at a half-period boundary, or while the counters are cleared. A change made in the middle of a half period leaves that half period unchanged. A change present in the boundary cycle itself governs the next half period.
- R6: When `stop_req` is high at a half-period boundary, `scl_o` ends that boundary at 1, or stays at 1, and no further SCL edges occur until the stop completes.
- R7: After the stop boundary, `bus_free` rises on the last tick of the second following half period: one half period of stop setup, then one half period of bus-free time. While `bus_free` is high and `stop_req` stays high, no `half_tick` occurs and `scl_o` stays 1.
- R8: When `stop_req` is low while `bus_free` is high, `bus_free` drops at the next clock edge. Clocking restarts with SCL high and a full half period before the first falling edge.
- R9: Dropping `enable` in the middle of a half period forces `scl_o` to 1 at the next clock edge. After re-enabling, the first half period is full length.
- R10: Cycles without a baud tick advance nothing: `scl_o` and the internal counts stay unchanged, and no `half_tick` occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brg_tick | input | 1 | One-cycle baud-rate enable pulse |
| div_val | input | DIV_W | Divider value; half period is (div_val + 3) prescaled ticks |
| pre_sel | input | 2 | Prescale select: 0→1, 1→4, 2→16, 3→32 |
| enable | input | 1 | Runs the generator; low clears it and parks SCL high |
| stop_req | input | 1 | Requests SCL to be parked high, followed by the stop and bus-free windows |
| scl_o | output | 1 | Serial clock level |
| scl_toggle | output | 1 | One-cycle strobe when scl_o changed |
| half_tick | output | 1 | One-cycle strobe at each half-period boundary |
| bus_free | output | 1 | High once the stop-setup and bus-free windows have elapsed |

## Verification
Two pairs of events can land in the same cycle. A stop request can meet a half-period boundary, and a new divider value can meet a boundary. The bench counts baud ticks from the last SCL edge and changes `stop_req` or `div_val` just before the tick that closes the half period. It then judges which half period the change governs. For the stop, it expects SCL to rise at that boundary and `bus_free` to follow exactly two half periods later. For the divider, it expects the very next half period to take the new length, while an identical change made mid-half leaves the current half untouched.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SETUP = 2'd1,
    PH_GAP   = 2'd2,
    PH_FREE  = 2'd3
  } sclgen_phase_e;

  // prescale select encoding: 0->1, 1->4, 2->16, 3->32
  function automatic int unsigned prescale_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 16;
      default: return 32;
    endcase
  endfunction

  // half period in prescaled units, raised so that units*pre >= min_brg
  function automatic int unsigned half_units(input int unsigned div,
                                             input int unsigned offset,
                                             input int unsigned pre,
                                             input int unsigned min_brg);
    int unsigned base;
    int unsigned floor_u;
    base    = div + offset;
    floor_u = (min_brg + pre - 1) / pre;
    return (base < floor_u) ? floor_u : base;
  endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int PRE_CW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              brg_tick,
  input  logic [PRE_CW-1:0] pre_lim,
  output logic              pre_tick
);
  logic [PRE_CW-1:0] cnt_q;
  logic              at_last;

  assign at_last  = (cnt_q == pre_lim - PRE_CW'(1));
  assign pre_tick = brg_tick && !clr && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (brg_tick) cnt_q <= at_last ? '0 : cnt_q + PRE_CW'(1);
  end

  // R2: prescale count stays below the selected division
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < pre_lim);

  // R10: count does not move without a baud tick
  a_r10_pre_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!brg_tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/sclgen_halfcnt.sv
module sclgen_halfcnt #(
  parameter int HC_W    = 9,
  parameter int OBS_W   = 15,
  parameter int MIN_BRG = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            brg_tick,
  input  logic            pre_tick,
  input  logic [HC_W-1:0] half_len,
  output logic            boundary
);
  logic [HC_W-1:0]  cnt_q;
  logic [OBS_W-1:0] brg_seen_q;   // baud ticks since last boundary, for checks
  logic             at_last;

  assign at_last  = (cnt_q == half_len - HC_W'(1));
  assign boundary = pre_tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (pre_tick) cnt_q <= at_last ? '0 : cnt_q + HC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 brg_seen_q <= '0;
    else if (clr || boundary)   brg_seen_q <= '0;
    else if (brg_tick)          brg_seen_q <= brg_seen_q + OBS_W'(1);
  end

  // R2: half counter stays inside the active half length
  a_r2_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_len);

  // R3: a boundary closes a half period of at least MIN_BRG baud ticks
  a_r3_min_half: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> (32'(brg_seen_q) >= 32'(MIN_BRG - 1)));

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import i2c_sclgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stop_req,
  input  logic boundary,
  output logic scl_o,
  output logic scl_toggle,
  output logic half_tick,
  output logic bus_free,
  output logic cnt_clr,
  output logic cfg_load
);
  sclgen_phase_e phase_q;

  assign bus_free = (phase_q == PH_FREE);
  assign cnt_clr  = !enable || (bus_free && stop_req);
  assign cfg_load = cnt_clr || boundary;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase_q    <= PH_RUN;
      scl_o      <= 1'b1;
      scl_toggle <= 1'b0;
      half_tick  <= 1'b0;
    end else begin
      half_tick  <= boundary;
      scl_toggle <= 1'b0;
      case (phase_q)
        PH_RUN: begin
          if (boundary) begin
            if (stop_req) begin
              scl_o      <= 1'b1;
              scl_toggle <= !scl_o;
              phase_q    <= PH_SETUP;
            end else begin
              scl_o      <= !scl_o;
              scl_toggle <= 1'b1;
            end
          end
        end
        PH_SETUP: if (boundary) phase_q <= PH_GAP;
        PH_GAP:   if (boundary) phase_q <= PH_FREE;
        default:  if (!stop_req) phase_q <= PH_RUN;
      endcase
    end
  end

  // R1: disabled generator parks SCL high and is silent
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !half_tick && !scl_toggle && !bus_free));

  // R4: strobes are single-cycle and SCL edges only at boundaries
  a_r4_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
  a_r4_toggle_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    scl_toggle |-> half_tick);

  // R6: SCL is high whenever the bus is reported free
  a_r6_free_high: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> scl_o);

  // R7: bus becomes free only at the end of a half period
  a_r7_free_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> half_tick);

  // R8: releasing the stop clears the free flag on the next edge
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_free && !stop_req) |=> !bus_free);

endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen
  import i2c_sclgen_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int DIV_OFFSET   = 3,
  parameter int MIN_HALF_BRG = 24,
  parameter int PRE_MAX      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brg_tick,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       pre_sel,
  input  logic             enable,
  input  logic             stop_req,
  output logic             scl_o,
  output logic             scl_toggle,
  output logic             half_tick,
  output logic             bus_free
);
  localparam int HC_W   = DIV_W + 1;
  localparam int PRE_CW = $clog2(PRE_MAX + 1);
  localparam int OBS_W  = HC_W + PRE_CW;

  logic [DIV_W-1:0]  div_q;
  logic [1:0]        sel_q;
  logic [PRE_CW-1:0] pre_lim;
  logic [HC_W-1:0]   half_len;
  logic              cfg_load;
  logic              cnt_clr;
  logic              pre_tick;
  logic              boundary;

  // configuration is captured only when the counters are cleared or at a boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= '0;
    end else if (cfg_load) begin
      div_q <= div_val;
      sel_q <= pre_sel;
    end
  end

  assign pre_lim = PRE_CW'(prescale_of(sel_q));

  generate
    if (MIN_HALF_BRG > 0) begin : g_clamped
      assign half_len = HC_W'(half_units(32'(div_q), 32'(DIV_OFFSET),
                                         32'(prescale_of(sel_q)), 32'(MIN_HALF_BRG)));
    end else begin : g_unclamped
      assign half_len = HC_W'(32'(div_q) + 32'(DIV_OFFSET));
    end
  endgenerate

  sclgen_prescaler #(.PRE_CW(PRE_CW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .brg_tick (brg_tick),
    .pre_lim  (pre_lim),
    .pre_tick (pre_tick)
  );

  sclgen_halfcnt #(.HC_W(HC_W), .OBS_W(OBS_W), .MIN_BRG(MIN_HALF_BRG)) u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .brg_tick (brg_tick),
    .pre_tick (pre_tick),
    .half_len (half_len),
    .boundary (boundary)
  );

  sclgen_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .stop_req   (stop_req),
    .boundary   (boundary),
    .scl_o      (scl_o),
    .scl_toggle (scl_toggle),
    .half_tick  (half_tick),
    .bus_free   (bus_free),
    .cnt_clr    (cnt_clr),
    .cfg_load   (cfg_load)
  );

  // R10: SCL holds in any enabled cycle without a baud tick
  a_r10_scl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !brg_tick) |=> $stable(scl_o));

  // R5: a boundary only happens on a baud tick
  a_r5_boundary_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> brg_tick);

endmodule

// File: tb/i2c_scl_rategen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_rategen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       brg_tick = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic [1:0] pre_sel = 2'd0;
  logic       enable = 1'b0;
  logic       stop_req = 1'b0;
  logic       scl_o, scl_toggle, half_tick, bus_free;

  int total = 0;
  int fails = 0;
  int ht_cnt = 0;
  int tg_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_scl_rategen dut_i (
    .clk(clk), .rst_n(rst_n), .brg_tick(brg_tick), .div_val(div_val),
    .pre_sel(pre_sel), .enable(enable), .stop_req(stop_req),
    .scl_o(scl_o), .scl_toggle(scl_toggle), .half_tick(half_tick), .bus_free(bus_free)
  );

  always @(negedge clk) begin
    if (half_tick)  ht_cnt++;
    if (scl_toggle) tg_cnt++;
  end

  // stimulus table: divider, prescale select, expected half period in baud ticks
  localparam int NV = 10;
  localparam int V_DIV [NV] = '{30, 21, 5, 0, 10, 1, 3, 0, 2, 255};
  localparam int V_SEL [NV] = '{0, 0, 0, 0, 1, 1, 1, 2, 3, 3};
  localparam int V_EXP [NV] = '{33, 24, 24, 24, 52, 24, 24, 48, 160, 8256};
  localparam bit V_CLP [NV] = '{0, 0, 1, 1, 0, 1, 0, 0, 0, 0};

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // one baud tick, followed by three idle cycles
  task automatic tick();
    @(negedge clk) brg_tick = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) brg_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic count_scl(output int n);
    logic prev;
    prev = scl_o;
    n = 0;
    do begin tick(); n++; end while (scl_o == prev && n < 20000);
  endtask

  task automatic count_free(output int n);
    n = 0;
    do begin tick(); n++; end while (!bus_free && n < 20000);
  endtask

  task automatic restart(input int d, input int s, input bit stp);
    @(negedge clk) enable = 1'b0;
    stop_req = stp;
    div_val  = 8'(d);
    pre_sel  = 2'(s);
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n, h0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "scl after reset", int'(scl_o), 1);
    chk("R1", "half_tick after reset", int'(half_tick), 0);
    chk("R1", "toggle after reset", int'(scl_toggle), 0);
    chk("R1", "bus_free after reset", int'(bus_free), 0);

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      restart(V_DIV[v], V_SEL[v], 1'b0);
      h0 = ht_cnt; t0 = tg_cnt;
      count_scl(n);
      chk(V_CLP[v] ? "R3" : "R2", $sformatf("first half v%0d", v), n, V_EXP[v]);
      count_scl(n);
      chk(V_CLP[v] ? "R3" : "R2", $sformatf("second half v%0d", v), n, V_EXP[v]);
      if (v == 0) begin
        chk("R4", "half ticks over two halves", ht_cnt - h0, 2);
        chk("R4", "toggles over two halves", tg_cnt - t0, 2);
      end
    end

    // R5 mid-half change keeps current half, boundary-cycle change takes next half
    restart(30, 0, 1'b0);
    count_scl(n);
    ticks(10);
    div_val = 8'd50;
    count_scl(n);
    chk("R5", "half after mid change", n + 10, 33);
    count_scl(n);
    chk("R5", "half with new divider", n, 53);
    ticks(52);
    div_val = 8'd10;
    count_scl(n);
    chk("R5", "half closed by boundary-cycle change", n + 52, 53);
    count_scl(n);
    chk("R5", "half after boundary-cycle change", n, 24);

    // R6 / R7 stop arriving in the boundary cycle of a low phase
    restart(30, 0, 1'b0);
    count_scl(n);
    chk("R2", "scl low before stop", int'(scl_o), 0);
    ticks(32);
    stop_req = 1'b1;
    tick();
    chk("R6", "scl raised at stop boundary", int'(scl_o), 1);
    t0 = tg_cnt;
    count_free(n);
    chk("R7", "ticks to bus free", n, 66);
    chk("R6", "no scl edges during stop", tg_cnt - t0, 0);
    h0 = ht_cnt;
    ticks(40);
    chk("R7", "no half ticks while free", ht_cnt - h0, 0);
    chk("R7", "scl high while free", int'(scl_o), 1);
    chk("R7", "bus_free held", int'(bus_free), 1);

    // R8 release
    @(negedge clk) stop_req = 1'b0;
    @(posedge clk); #1;
    chk("R8", "bus_free drops", int'(bus_free), 0);
    count_scl(n);
    chk("R8", "first half after release", n, 33);

    // R6 stop requested during a high phase: SCL never falls
    restart(30, 0, 1'b1);
    t0 = tg_cnt;
    count_free(n);
    chk("R6", "ticks to free from high phase", n, 99);
    chk("R6", "no toggles from high phase", tg_cnt - t0, 0);
    @(negedge clk) stop_req = 1'b0;

    // R9 disable mid-run
    restart(30, 0, 1'b0);
    count_scl(n);
    ticks(7);
    @(negedge clk) enable = 1'b0;
    @(posedge clk); #1;
    chk("R9", "scl forced high", int'(scl_o), 1);
    @(negedge clk) enable = 1'b1;
    count_scl(n);
    chk("R9", "full half after re-enable", n, 33);

    // R10 no baud ticks
    ticks(5);
    h0 = ht_cnt;
    repeat (300) @(negedge clk);
    chk("R10", "scl held without ticks", int'(scl_o), 0);
    chk("R10", "no half ticks without ticks", ht_cnt - h0, 0);
    count_scl(n);
    chk("R10", "remaining half after pause", n + 5, 33);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule